// File: doc/BRIEF.md
# Single-Wire Bus Slot-Edge Glitch Filter

This block sits at the receive side of a slave on a single-wire open-drain bus. It runs from an oversampling clock and takes two digitized comparator results, one saying the line sits above the upper threshold and one saying it sits below the lower threshold. It turns them into a clean line level and a one-clock marker for the start of each time slot. A speed-mode input selects standard or overdrive timing.

Three mechanisms work together. First, hysteresis: the level only changes when the opposite comparator fires, so a sample between the thresholds keeps the previous level. Second, at standard speed a falling edge is accepted only after `FILT_LEN` consecutive below-threshold samples; at overdrive the first such sample is enough. Third, after every rise a hold-off window of `HOLD_STD` or `HOLD_OD` clocks ignores even deep low glitches. A low that is still present on the last sample of the window starts a new slot at once.

The controller has five states. `ST_HIGH` is high and idle. `ST_QUAL` is high while lows are being counted. `ST_START` is the single pulse cycle, with the line low. `ST_LOW` holds the accepted low. `ST_HOLD` is high inside the hold-off window. The transitions are:

- `ST_HIGH` to `ST_QUAL` on a below sample at standard speed, or to `ST_START` at overdrive.
- `ST_QUAL` back to `ST_HIGH` when the run of lows breaks, or on to `ST_START` when the count completes.
- `ST_START` to `ST_HOLD` on an above sample, otherwise to `ST_LOW`.
- `ST_LOW` to `ST_HOLD` on an above sample.
- `ST_HOLD` at its last sample goes to `ST_START` if below, otherwise to `ST_HIGH`.

`FILT_LEN` must be at least 2, and both hold lengths at least 1.

Top module: `owire_slot_filter`

## Requirements
- R1: Synchronous active-high reset gives `line_q`=1 (1 means high) and `slot_start`=0, with no hold-off window running: a below sample at overdrive right after reset produces a slot start in the next cycle.
- R2: A sample with both comparator inputs 0 leaves `line_q` unchanged in the next cycle, from high and from low, at both speeds, and produces no slot start.
- R3: At standard speed (`overdrive`=0) a low is accepted only after `FILT_LEN` consecutive samples with `below_lo`=1. `slot_start` and `line_q`=0 appear in the cycle after the last of them. A run broken by a sample with `below_lo`=0 produces nothing and restarts the count.
- R4: At overdrive (`overdrive`=1) a single `below_lo` sample from the idle high state is accepted, and `slot_start` follows in the next cycle.
- R5: `slot_start` lasts exactly one cycle and comes with `line_q`=0. `line_q` then stays 0 and no further `slot_start` occurs until `above_hi`=1 is sampled.
- R6: `above_hi` sampled while `line_q`=0 makes `line_q`=1 in the next cycle. It also starts a hold-off window of `HOLD_STD` samples (standard) or `HOLD_OD` samples (overdrive).
- R7: `below_lo` samples on the window's samples 1 to length-1 are ignored: `line_q` stays 1 and no slot start occurs.
- R8: `below_lo`=1 on the last sample of the window is taken as a new slot at once, with no falling-edge filtering: `slot_start` follows in the next cycle.
- R9: A window that ends without a low returns to the idle high state. Later lows are then qualified as in R3 and R4, so a slot after a rejected glitch is still found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| above_hi | input | 1 | Comparator: line above upper threshold |
| below_lo | input | 1 | Comparator: line below lower threshold |
| overdrive | input | 1 | Speed mode: 0 standard, 1 overdrive |
| line_q | output | 1 | Filtered line level, 1 = high |
| slot_start | output | 1 | One-cycle pulse when a slot begins |

## Verification
The hardest situation to reach is the last sample of the hold-off window. A deep low there must start a slot, while the same low one sample earlier must be ignored. That only happens after a full slot has been accepted and released. The stimulus therefore first drives a complete low period, then raises the line. It then counts exactly `HOLD_STD` or `HOLD_OD` samples, holding the line deep low on every sample of the window but the last, and decides the last one separately. It checks both the ignored samples and the accepted last one, at each speed.

// File: rtl/ofl_pkg.sv
package ofl_pkg;
    typedef enum logic [2:0] {
        ST_HIGH  = 3'd0,
        ST_QUAL  = 3'd1,
        ST_START = 3'd2,
        ST_LOW   = 3'd3,
        ST_HOLD  = 3'd4
    } ofl_state_e;
endpackage

// File: rtl/ofl_cycle_counter.sv
module ofl_cycle_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/ofl_window_limit.sv
module ofl_window_limit #(
    parameter int HOLD_STD = 12,
    parameter int HOLD_OD  = 3,
    parameter int W        = 4
) (
    input  logic         overdrive,
    output logic [W-1:0] last_idx
);
    localparam logic [W-1:0] LAST_STD = W'(HOLD_STD - 1);
    localparam logic [W-1:0] LAST_OD  = W'(HOLD_OD - 1);

    // index of the final window sample for the selected speed
    always_comb last_idx = overdrive ? LAST_OD : LAST_STD;
endmodule

// File: rtl/owire_slot_filter.sv
module owire_slot_filter
    import ofl_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int HOLD_STD = 12,
    parameter int HOLD_OD  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic above_hi,
    input  logic below_lo,
    input  logic overdrive,
    output logic line_q,
    output logic slot_start
);
    localparam int MAX_A = (HOLD_STD > HOLD_OD) ? HOLD_STD : HOLD_OD;
    localparam int MAX_V = (MAX_A > FILT_LEN) ? MAX_A : FILT_LEN;
    localparam int CNT_W = $clog2(MAX_V + 1);
    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(FILT_LEN - 2);

    ofl_state_e       st, nxt;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt, hold_last;

    ofl_cycle_counter #(.W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    ofl_window_limit #(.HOLD_STD(HOLD_STD), .HOLD_OD(HOLD_OD), .W(CNT_W)) i_lim (
        .overdrive (overdrive),
        .last_idx  (hold_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            st <= ST_HIGH;
        else
            st <= nxt;
    end

    // transitions
    always_comb begin
        nxt     = st;
        cnt_inc = 1'b0;
        unique case (st)
            ST_HIGH: begin
                if (below_lo)
                    nxt = overdrive ? ST_START : ST_QUAL;
            end
            ST_QUAL: begin
                if (!below_lo)
                    nxt = ST_HIGH;
                else if (cnt == QUAL_LAST)
                    nxt = ST_START;
                else
                    cnt_inc = 1'b1;
            end
            ST_START: begin
                nxt = above_hi ? ST_HOLD : ST_LOW;
            end
            ST_LOW: begin
                if (above_hi)
                    nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (cnt >= hold_last)
                    nxt = below_lo ? ST_START : ST_HIGH;
                else
                    cnt_inc = 1'b1;
            end
            default: nxt = ST_HIGH;
        endcase
        cnt_clr = (nxt != st);
    end

    // outputs decoded from state
    always_comb begin
        line_q     = !((st == ST_START) || (st == ST_LOW));
        slot_start = (st == ST_START);
    end
endmodule

// File: rtl/owire_slot_filter_chk.sv
module owire_slot_filter_chk (
    input logic clk,
    input logic rst,
    input logic above_hi,
    input logic below_lo,
    input logic line_q,
    input logic slot_start
);
    p_hyst_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!above_hi && !below_lo) |=> $stable(line_q));

    p_start_after_low_r3: assert property (@(posedge clk) disable iff (rst)
        slot_start |-> $past(below_lo));

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> !slot_start);

    p_pulse_with_low_r5: assert property (@(posedge clk) disable iff (rst)
        slot_start |-> !line_q);

    p_low_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (!line_q && !above_hi) |=> (!line_q && !slot_start));

    p_rise_release_r6: assert property (@(posedge clk) disable iff (rst)
        (!line_q && above_hi) |=> line_q);
endmodule

bind owire_slot_filter owire_slot_filter_chk i_chk (.*);

// File: tb/test_owire_slot_filter.sv
module test_owire_slot_filter;
    localparam int FILT = 4;
    localparam int HS   = 12;
    localparam int HO   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic above_hi = 1'b1;
    logic below_lo = 1'b0;
    logic overdrive = 1'b0;
    logic line_q, slot_start;
    logic ss_s, lq_s;
    int   n_chk = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;

    owire_slot_filter #(.FILT_LEN(FILT), .HOLD_STD(HS), .HOLD_OD(HO)) i_owire_slot_filter (
        .clk        (clk),
        .rst        (rst),
        .above_hi   (above_hi),
        .below_lo   (below_lo),
        .overdrive  (overdrive),
        .line_q     (line_q),
        .slot_start (slot_start)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one sample: drive at negedge, observe just after the following posedge
    task automatic cyc(input logic ah, input logic bl);
        @(negedge clk);
        above_hi = ah;
        below_lo = bl;
        @(posedge clk);
        #1;
        ss_s = slot_start;
        lq_s = line_q;
    endtask

    task automatic do_reset(input logic od);
        @(negedge clk);
        rst = 1'b1;
        above_hi = 1'b1;
        below_lo = 1'b0;
        overdrive = od;
        repeat (2) @(posedge clk);
        #1;
        check("R1", "reset line_q", int'(line_q), 1);
        check("R1", "reset slot_start", int'(slot_start), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // reset, then drive a qualified low; returns with the slot accepted
    task automatic go_low(input logic od);
        do_reset(od);
        repeat (od ? 1 : FILT) cyc(1'b0, 1'b1);
    endtask

    task automatic t_reset_overdrive;
        do_reset(1'b1);
        cyc(1'b0, 1'b1);
        check("R1", "no window after reset, od start", int'(ss_s), 1);
        check("R4", "od low accepted", int'(lq_s), 0);
        cyc(1'b0, 1'b1);
        check("R5", "pulse one cycle", int'(ss_s), 0);
        check("R5", "line stays low", int'(lq_s), 0);
    endtask

    task automatic t_std_slot;
        int pulses;
        pulses = 0;
        do_reset(1'b0);
        for (int i = 1; i <= FILT; i++) begin
            cyc(1'b0, 1'b1);
            if (i < FILT) begin
                check("R3", "no early start", int'(ss_s), 0);
                check("R3", "line high while qualifying", int'(lq_s), 1);
            end else begin
                check("R3", "start after FILT samples", int'(ss_s), 1);
                check("R3", "line low after FILT samples", int'(lq_s), 0);
            end
        end
        for (int i = 0; i < 8; i++) begin
            cyc(1'b0, 1'b1);
            if (ss_s) pulses++;
        end
        check("R5", "no second pulse in low period", pulses, 0);
        check("R5", "line held low", int'(lq_s), 0);
    endtask

    task automatic t_std_reject;
        int pulses;
        pulses = 0;
        do_reset(1'b0);
        repeat (FILT - 1) begin
            cyc(1'b0, 1'b1);
            if (ss_s) pulses++;
        end
        cyc(1'b0, 1'b0);
        if (ss_s) pulses++;
        check("R3", "broken run gives no start", pulses, 0);
        check("R3", "line high after broken run", int'(lq_s), 1);
        for (int i = 1; i <= FILT; i++) begin
            cyc(1'b0, 1'b1);
            if (i < FILT && ss_s) pulses++;
        end
        check("R3", "count restarted after break", pulses, 0);
        check("R3", "start on FILT-th fresh sample", int'(ss_s), 1);
    endtask

    task automatic t_hysteresis;
        int changes;
        for (int od = 0; od < 2; od++) begin
            changes = 0;
            do_reset(1'(od));
            repeat (10) begin
                cyc(1'b0, 1'b0);
                if (!lq_s || ss_s) changes++;
            end
            check("R2", "shallow dip keeps high", changes, 0);
            go_low(1'(od));
            changes = 0;
            repeat (10) begin
                cyc(1'b0, 1'b0);
                if (lq_s || ss_s) changes++;
            end
            check("R2", "mid level keeps low", changes, 0);
        end
    endtask

    // deep glitch on window samples 1..len-1, then decide the last sample
    task automatic t_window(input logic od, input logic late_low);
        int len, pulses, highs;
        len = od ? HO : HS;
        pulses = 0;
        highs = 0;
        go_low(od);
        cyc(1'b1, 1'b0);
        check("R6", "rise releases line", int'(lq_s), 1);
        for (int j = 1; j < len; j++) begin
            cyc(1'b0, 1'b1);
            if (ss_s) pulses++;
            if (lq_s) highs++;
        end
        check("R7", "window glitch no start", pulses, 0);
        check("R7", "window glitch line high", highs, len - 1);
        if (late_low) begin
            cyc(1'b0, 1'b1);
            check("R8", "late low starts slot", int'(ss_s), 1);
            check("R8", "late low line low", int'(lq_s), 0);
        end else begin
            cyc(1'b1, 1'b0);
            check("R9", "window expiry no start", int'(ss_s), 0);
            for (int i = 1; i <= (od ? 1 : FILT); i++) begin
                cyc(1'b0, 1'b1);
                if (i < (od ? 1 : FILT))
                    check("R9", "filter applies after window", int'(ss_s), 0);
            end
            check("R9", "slot found after glitch", int'(ss_s), 1);
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        t_reset_overdrive();
        t_std_slot();
        t_std_reject();
        t_hysteresis();
        t_window(1'b0, 1'b0);
        t_window(1'b0, 1'b1);
        t_window(1'b1, 1'b0);
        t_window(1'b1, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule